// File: doc/BRIEF.md
# Codec Response Ring Writer

This block takes 32-bit responses coming back from attached codecs and stores them in a circular ring in memory. Each response arrives with a codec address and a flag that marks it as unsolicited. The block writes the response word and a flags word to the next free entry through a simple memory write port. It then advances a hardware write pointer that software reads to find new entries. Software reports how far it has consumed the ring through a read-pointer input. A response that would overwrite an unread entry is dropped and flagged as an overrun.

The ring length is chosen at run time from 2, 16 or 256 entries. Interrupts are coalesced by a programmable response count. Status flags are cleared by writing one. A small register port gives access to ring size, control, status, write pointer and interrupt threshold. The register map is: 0 size, 1 control, 2 status, 3 write pointer, 4 threshold. Register reads are combinational; writes take effect at the clock edge.

Top module: `resp_ring_writer`

## Requirements
- R1: After reset the write pointer reads 0, status reads 0, control reads 0, `irq` is low, and the size register (address 0) reads 0x0070.
- R2: Each accepted response is written to entry (wp+1) mod length, where wp is the write pointer. The write drives `mem_resp` with the response and `mem_flags` with the codec address in bits [3:0], the unsolicited bit in bit 4 and zeros above. The write pointer then reads that entry index. The ring's first entry after reset is 1.
- R3: Size register bits [1:0] select the ring length: 0 gives 2, 1 gives 16, 2 gives 256. Bits [6:4] are a read-only capability field that always reads 3'b111. Entry indices wrap at the selected length.
- R4: Writing the write-pointer register (address 3) with bit 15 set returns the write pointer to 0.
- R5: While control bit 0 (ring enable) is 0, `rsp_ready` is low and no entry is written. Disabling the ring also clears the response count.
- R6: The response flag (status bit 0) is set when the number of stored responses since the last match reaches the threshold register (address 4, bits [7:0]). A threshold of 1 flags every response. A threshold of 0 never flags.
- R7: If (wp+1) mod length equals `sw_rd_ptr` (the entry software most recently finished), an accepted response is dropped. The write pointer is unchanged, the drop is not counted toward the threshold, and status bit 2 (overrun) is set.
- R8: Writing 1 to status bit 0 or bit 2 clears that bit. Writing 0 leaves it unchanged.
- R9: `irq` is high exactly when (status bit 0 and control bit 1) or (status bit 2 and control bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Response accepted this cycle when valid |
| rsp_data | input | 32 | Response word |
| rsp_codec | input | 4 | Codec address of the response |
| rsp_unsol | input | 1 | Response is unsolicited |
| sw_rd_ptr | input | 8 | Entry most recently consumed by software |
| mem_we | output | 1 | Ring entry write strobe |
| mem_addr | output | 8 | Ring entry index |
| mem_resp | output | 32 | Response word to store |
| mem_flags | output | 32 | Flags word to store |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
Responses are driven with varied codec addresses and unsolicited flags, so a swapped or misplaced flags field shows up in the stored word. Streams are run at all three ring lengths, with software read pointers placed to force a wrap to entry 0 and a drop at a full ring. These runs separate correct masking from a pointer that runs past the ring, and a dropped response from one that is silently written. Thresholds of 1, 3 and 0 are used, and the ring is switched off between partial counts. This shows whether the count is coalesced, cleared on disable, and left uncharged by drops.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int RSP_W    = 32;
  localparam int PTR_W    = 8;
  localparam int SMALL_W  = 4;
  localparam int CAD_W    = 4;
  localparam int REG_AW   = 3;
  localparam int REG_DW   = 16;
  localparam int UNSOL_B  = CAD_W;
  localparam int CAP_LSB  = 4;
  localparam int WPCLR_B  = 15;

  localparam logic [REG_AW-1:0] A_SIZE = 3'd0;
  localparam logic [REG_AW-1:0] A_CTRL = 3'd1;
  localparam logic [REG_AW-1:0] A_STAT = 3'd2;
  localparam logic [REG_AW-1:0] A_WPTR = 3'd3;
  localparam logic [REG_AW-1:0] A_THR  = 3'd4;

  typedef enum logic [1:0] {
    LEN_2   = 2'd0,
    LEN_16  = 2'd1,
    LEN_256 = 2'd2
  } ring_len_e;

  function automatic logic [PTR_W-1:0] len_mask(input logic [1:0] sel);
    case (sel)
      LEN_2:   len_mask = PTR_W'(1);
      LEN_16:  len_mask = PTR_W'((1 << SMALL_W) - 1);
      default: len_mask = {PTR_W{1'b1}};
    endcase
  endfunction
endpackage

// File: rtl/rr_wptr.sv
module rr_wptr
  import rr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       len_sel,
  input  logic             clr,
  input  logic             adv,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] wp,
  output logic [PTR_W-1:0] slot,
  output logic             full
);
  logic [PTR_W-1:0] wp_q, wp_d, mask;

  always_comb begin
    mask = len_mask(len_sel);
    slot = (wp_q + PTR_W'(1)) & mask;
    full = (slot == (rd_ptr & mask));
    wp   = wp_q & mask;
    wp_d = wp_q;
    if (clr)      wp_d = '0;
    else if (adv) wp_d = slot;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wp_q <= '0;
    else        wp_q <= wp_d;

  p_wp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (wp_q == $past(slot)));
  p_no_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (slot != (rd_ptr & mask)));
  p_wp_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wp_q == '0));
endmodule

// File: rtl/rr_coalesce.sv
module rr_coalesce
  import rr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hit,
  input  logic [PTR_W-1:0] thr,
  output logic             tick
);
  logic [PTR_W-1:0] cnt_q, cnt_d;
  logic [PTR_W:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + (PTR_W+1)'(1);
    tick    = hit && (cnt_inc == {1'b0, thr});
    cnt_d   = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (hit)  cnt_d = cnt_inc[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  p_cnt_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
  p_tick_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en) |=> (cnt_q == '0));
endmodule

// File: rtl/resp_ring_writer.sv
module resp_ring_writer
  import rr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [RSP_W-1:0]  rsp_data,
  input  logic [CAD_W-1:0]  rsp_codec,
  input  logic              rsp_unsol,
  input  logic [PTR_W-1:0]  sw_rd_ptr,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [RSP_W-1:0]  mem_resp,
  output logic [RSP_W-1:0]  mem_flags,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq
);
  localparam logic [2:0] CAPS = 3'b111;

  logic [1:0]       sel_q, sel_d;
  logic             dma_q, dma_d, rie_q, rie_d, oie_q, oie_d;
  logic             sresp_q, sresp_d, sovr_q, sovr_d;
  logic [PTR_W-1:0] thr_q, thr_d;
  logic [PTR_W-1:0] wp, slot;
  logic             full, fire, store, drop, tick, wp_clr;
  logic             wr_size, wr_ctrl, wr_stat, wr_thr;

  assign rsp_ready = dma_q;
  assign fire      = rsp_valid && dma_q;
  assign store     = fire && !full;
  assign drop      = fire && full;
  assign wr_size   = reg_we && (reg_addr == A_SIZE);
  assign wr_ctrl   = reg_we && (reg_addr == A_CTRL);
  assign wr_stat   = reg_we && (reg_addr == A_STAT);
  assign wr_thr    = reg_we && (reg_addr == A_THR);
  assign wp_clr    = reg_we && (reg_addr == A_WPTR) && reg_wdata[WPCLR_B];

  rr_wptr u_wptr (
    .clk(clk), .rst_n(rst_n), .len_sel(sel_q), .clr(wp_clr), .adv(store),
    .rd_ptr(sw_rd_ptr), .wp(wp), .slot(slot), .full(full)
  );

  rr_coalesce u_coal (
    .clk(clk), .rst_n(rst_n), .en(dma_q), .hit(store), .thr(thr_q), .tick(tick)
  );

  always_comb begin
    mem_we    = store;
    mem_addr  = slot;
    mem_resp  = rsp_data;
    mem_flags = '0;
    mem_flags[CAD_W-1:0] = rsp_codec;
    mem_flags[UNSOL_B]   = rsp_unsol;
  end

  always_comb begin
    sel_d   = wr_size ? reg_wdata[1:0] : sel_q;
    dma_d   = wr_ctrl ? reg_wdata[0]   : dma_q;
    rie_d   = wr_ctrl ? reg_wdata[1]   : rie_q;
    oie_d   = wr_ctrl ? reg_wdata[2]   : oie_q;
    thr_d   = wr_thr  ? reg_wdata[PTR_W-1:0] : thr_q;
    sresp_d = (sresp_q && !(wr_stat && reg_wdata[0])) || tick;
    sovr_d  = (sovr_q  && !(wr_stat && reg_wdata[2])) || drop;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= LEN_2; dma_q <= 1'b0; rie_q <= 1'b0; oie_q <= 1'b0;
      thr_q <= '0; sresp_q <= 1'b0; sovr_q <= 1'b0;
    end else begin
      sel_q <= sel_d; dma_q <= dma_d; rie_q <= rie_d; oie_q <= oie_d;
      thr_q <= thr_d; sresp_q <= sresp_d; sovr_q <= sovr_d;
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SIZE: begin
        reg_rdata[1:0]             = sel_q;
        reg_rdata[CAP_LSB+2:CAP_LSB] = CAPS;
      end
      A_CTRL: reg_rdata[2:0] = {oie_q, rie_q, dma_q};
      A_STAT: begin
        reg_rdata[0] = sresp_q;
        reg_rdata[2] = sovr_q;
      end
      A_WPTR: reg_rdata[PTR_W-1:0] = wp;
      A_THR:  reg_rdata[PTR_W-1:0] = thr_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = (sresp_q && rie_q) || (sovr_q && oie_q);

  p_dma_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_q |-> !mem_we);
  p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> sovr_q);
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sresp_q);
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[0] && !tick) |=> !sresp_q);
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rie_q && !oie_q) |-> !irq);
endmodule

// File: tb/resp_ring_writer_test.sv
module resp_ring_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rsp_valid = 1'b0, rsp_unsol = 1'b0;
  logic [31:0] rsp_data = '0;
  logic [3:0]  rsp_codec = '0;
  logic [7:0]  sw_rd_ptr = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        rsp_ready, mem_we, irq;
  logic [7:0]  mem_addr;
  logic [31:0] mem_resp, mem_flags;
  logic [15:0] reg_rdata;

  int n_run = 0, n_fail = 0;
  logic [7:0] wp_m = '0, mask_m = 8'h01;
  logic [71:0] exp_q [$];

  always #5 clk = ~clk;

  resp_ring_writer uut (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_codec(rsp_codec), .rsp_unsol(rsp_unsol),
    .sw_rd_ptr(sw_rd_ptr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_resp(mem_resp), .mem_flags(mem_flags), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected entries as writes appear
  always @(negedge clk) if (rst_n && mem_we) begin
    if (exp_q.size() == 0) check("R2 unexpected write", {24'h0, mem_addr}, 32'hFFFF_FFFF);
    else begin
      logic [71:0] e;
      e = exp_q.pop_front();
      check("R2 entry index", {24'h0, mem_addr}, {24'h0, e[71:64]});
      check("R2 response word", mem_resp, e[63:32]);
      check("R2 flags word", mem_flags, e[31:0]);
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    if (a == 3'd0) mask_m = (d[1:0] == 2'd0) ? 8'h01 : (d[1:0] == 2'd1) ? 8'h0F : 8'hFF;
    if (a == 3'd3 && d[15]) wp_m = '0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  task automatic send(input logic [31:0] dat, input logic [3:0] cad, input logic un);
    logic [7:0] nxt;
    @(posedge clk); #1;
    rsp_valid = 1'b1; rsp_data = dat; rsp_codec = cad; rsp_unsol = un;
    nxt = (wp_m + 8'd1) & mask_m;
    if (nxt != (sw_rd_ptr & mask_m)) begin
      exp_q.push_back({nxt, dat, 27'h0, un, cad});
      wp_m = nxt;
    end
    @(posedge clk); #1;
    rsp_valid = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rreg(a, d);
    check(req, {16'h0, d}, {16'h0, exp});
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk_reg("R1 wptr", 3'd3, 16'h0000);
    chk_reg("R1 status", 3'd2, 16'h0000);
    chk_reg("R1 ctrl", 3'd1, 16'h0000);
    chk_reg("R1 size", 3'd0, 16'h0070);
    check("R1 irq", {31'h0, irq}, 32'h0);
    // R5 ring disabled
    @(posedge clk); #1;
    rsp_valid = 1'b1; rsp_data = 32'hDEAD_0001; #1;
    check("R5 ready low when disabled", {31'h0, rsp_ready}, 32'h0);
    @(posedge clk); #1 rsp_valid = 1'b0;
    chk_reg("R5 wptr unchanged", 3'd3, 16'h0000);
    // R3 capability read-only, length 16
    wreg(3'd0, 16'h0001);
    chk_reg("R3 size sel and caps", 3'd0, 16'h0071);
    wreg(3'd4, 16'd1);
    wreg(3'd1, 16'h0003);
    send(32'h1111_0001, 4'h2, 1'b0);
    send(32'h2222_0002, 4'hF, 1'b1);
    send(32'h3333_0003, 4'h5, 1'b0);
    chk_reg("R2 wptr after three", 3'd3, 16'd3);
    chk_reg("R6 flag with threshold 1", 3'd2, 16'h0001);
    check("R9 irq resp enabled", {31'h0, irq}, 32'h1);
    wreg(3'd2, 16'h0001);
    chk_reg("R8 w1c resp", 3'd2, 16'h0000);
    check("R9 irq after clear", {31'h0, irq}, 32'h0);
    // R6 threshold 3
    wreg(3'd4, 16'd3);
    send(32'hA0, 4'h1, 1'b1);
    send(32'hA1, 4'h3, 1'b0);
    chk_reg("R6 no flag below count", 3'd2, 16'h0000);
    send(32'hA2, 4'h7, 1'b1);
    chk_reg("R6 flag at count", 3'd2, 16'h0001);
    wreg(3'd2, 16'h0000);
    chk_reg("R8 write zero keeps", 3'd2, 16'h0001);
    wreg(3'd2, 16'h0001);
    // R7 fill and overrun at length 16
    for (int i = 0; i < 9; i++) send(32'hB000 + i, 4'(i), i[0]);
    chk_reg("R2 wptr at top", 3'd3, 16'd15);
    wreg(3'd2, 16'h0001);
    send(32'hBAD0, 4'h9, 1'b0);
    chk_reg("R7 wptr held on drop", 3'd3, 16'd15);
    chk_reg("R7 overrun bit", 3'd2, 16'h0004);
    check("R9 overrun masked", {31'h0, irq}, 32'h0);
    wreg(3'd1, 16'h0007);
    check("R9 overrun enabled", {31'h0, irq}, 32'h1);
    wreg(3'd2, 16'h0004);
    chk_reg("R8 w1c overrun", 3'd2, 16'h0000);
    // wrap to entry 0
    sw_rd_ptr = 8'd5;
    send(32'hC000, 4'hA, 1'b1);
    send(32'hC001, 4'hB, 1'b0);
    chk_reg("R3 wrap at 16", 3'd3, 16'd1);
    // R4 pointer reset
    wreg(3'd3, 16'h8000);
    chk_reg("R4 wptr cleared", 3'd3, 16'd0);
    send(32'hD000, 4'h4, 1'b0);
    chk_reg("R4 next entry 1", 3'd3, 16'd1);
    // length 2
    wreg(3'd0, 16'h0000);
    sw_rd_ptr = 8'd0;
    wreg(3'd2, 16'h0005);
    send(32'hE000, 4'h6, 1'b1);
    chk_reg("R7 drop at length 2", 3'd2, 16'h0004);
    sw_rd_ptr = 8'd1;
    send(32'hE001, 4'h6, 1'b1);
    chk_reg("R3 wrap at 2", 3'd3, 16'd0);
    // length 256, threshold 0
    wreg(3'd0, 16'h0002);
    wreg(3'd3, 16'h8000);
    wreg(3'd4, 16'd0);
    wreg(3'd2, 16'h0005);
    sw_rd_ptr = 8'd0;
    for (int i = 0; i < 255; i++) send(32'hF000_0000 + i, 4'(i), i[1]);
    chk_reg("R3 wptr at 255", 3'd3, 16'd255);
    chk_reg("R6 threshold 0 never flags", 3'd2, 16'h0000);
    send(32'hF0FF, 4'h1, 1'b0);
    chk_reg("R7 drop at length 256", 3'd2, 16'h0004);
    // R5 count cleared by disable
    wreg(3'd0, 16'h0001);
    wreg(3'd3, 16'h8000);
    wreg(3'd4, 16'd3);
    wreg(3'd2, 16'h0005);
    send(32'h5500, 4'h2, 1'b0);
    send(32'h5501, 4'h2, 1'b0);
    wreg(3'd1, 16'h0000);
    wreg(3'd1, 16'h0003);
    send(32'h5502, 4'h2, 1'b0);
    send(32'h5503, 4'h2, 1'b0);
    chk_reg("R5 count restarted after disable", 3'd2, 16'h0000);
    send(32'h5504, 4'h2, 1'b0);
    chk_reg("R5 flag after fresh count", 3'd2, 16'h0001);
    repeat (2) @(posedge clk);
    check("R2 all expected writes seen", exp_q.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule